// File: doc/BRIEF.md
# Interrupt Pending and Entry Controller

This block collects a bank of level interrupt request lines into a sticky pending register and, at every instruction boundary, decides whether the processor must leave its current flow and enter the interrupt handler. A line that is seen high sets its pending bit, and the bit stays set until software clears it, so a short pulse is never lost. The pending bits are qualified by a per-line mask and by a global enable bit. When an instruction completes and at least one unmasked pending line exists with the global enable set, the block raises a one-cycle take pulse.

On the same cycle it presents the handler address: the exception base register plus a fixed slot index times 32 bytes. On the following edge it captures the program counter as the return address and rewrites the enable register so that the old enable sits in a saved bit and the global enable is cleared. A restore strobe, used on return from the handler, moves the saved bit back into the global enable. Software reaches the pending, mask, enable and base registers through a small two-bit-addressed register port with a combinational read path.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the pending, mask, enable, base and return-address registers read zero and the take pulse is low.
- R2: A request line seen high at a clock edge sets the pending bit of the same index (line n to bit n), readable at register address 0 from the next cycle.
- R3: A pending bit stays set after its line drops; only a software clear removes it.
- R4: A write to address 0 clears each pending bit whose write-data bit is 1 (write-one-to-clear); a line high in the same cycle as its clear leaves the bit set.
- R5: The take pulse is high in a cycle exactly when the boundary strobe is high, enable bit 0 is 1, and the AND of mask (address 1) and pending is nonzero.
- R6: Without the boundary strobe no interrupt is taken, whatever the pending, mask and enable state.
- R7: The base register (address 3) stores the written value with bits 7:0 forced to zero; the target output equals base plus the slot index (default 6) times 32.
- R8: On the edge that ends a take cycle the return-address output captures the program counter presented in that cycle.
- R9: On the edge that ends a take cycle the enable register (address 2, bit 1 saved enable, bit 0 global enable) becomes binary 10.
- R10: A restore strobe without a take copies enable bit 1 into bit 0 and clears bit 1; a take in the same cycle wins over a restore, which wins over a software write of the enable register.
- R11: An interrupt held off by its mask or by the global enable is taken at the first boundary after it becomes serviceable, with its pending bit still set.
- R12: The mask register reads back all 32 written bits; the enable register keeps only write-data bits 1:0 and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 32 | Interrupt request lines, active high |
| insn_done_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | Current program counter |
| restore_i | input | 1 | Return-from-handler enable restore strobe |
| csr_wr_i | input | 1 | Register write enable |
| csr_addr_i | input | 2 | Register select: 0 pending, 1 mask, 2 enable, 3 base |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data for csr_addr_i |
| take_irq_o | output | 1 | Interrupt entry pulse |
| target_o | output | 32 | Handler address |
| ret_addr_o | output | 32 | Saved return address |
| ie_o | output | 2 | Enable register {saved, global} |

## Verification
Every one of the 32 lines is driven alone, each as a single-cycle pulse, with its mask bit alone set and then with every other mask bit set, so a wrong bit index, a non-sticky pending bit or a leaking mask shows as a pending readback or take mismatch on that line only. For each line the boundary strobe is first held low and then raised with the enable both set and already cleared by the entry, separating the three conditions of the take decision. A line raised in the same cycle as its own clear tells set-dominant from clear-dominant pending logic, and the held-off case distinguishes a decision made once from one re-evaluated at each boundary.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_MASK = 2'd1,
        SEL_ENAB = 2'd2,
        SEL_BASE = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic saved;
        logic gie;
    } ie_t;

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
    parameter int NLINES = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NLINES-1:0] lines_i,
    input  logic              clr_en_i,
    input  logic [NLINES-1:0] clr_bits_i,
    output logic [NLINES-1:0] pend_o
);

    typedef struct packed {
        logic [NLINES-1:0] pend;
    } pend_state_t;

    pend_state_t s_d, s_q;
    logic [NLINES-1:0] keep_w;

    // per-line cell: clear first, then set, so a live line dominates
    for (genvar g = 0; g < NLINES; g++) begin : g_cell
        assign keep_w[g] = s_q.pend[g] & ~(clr_en_i & clr_bits_i[g]);
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = keep_w | lines_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pend_o = s_q.pend;

endmodule

// File: rtl/irq_mask_base.sv
module irq_mask_base #(
    parameter int NLINES     = 32,
    parameter int XLEN       = 32,
    parameter int BASE_ALIGN = 8,
    parameter int VEC_ID     = 6,
    parameter int SLOT_SHIFT = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mask_we_i,
    input  logic              base_we_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [NLINES-1:0] mask_o,
    output logic [XLEN-1:0]   base_o,
    output logic [XLEN-1:0]   target_o
);

    localparam logic [XLEN-1:0] LOW_MASK = XLEN'((1 << BASE_ALIGN) - 1);
    localparam logic [XLEN-1:0] VEC_OFS  = XLEN'(VEC_ID) << SLOT_SHIFT;

    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic [XLEN-1:0]   base;
    } mb_state_t;

    mb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mask_we_i) s_d.mask = wdata_i[NLINES-1:0];
        if (base_we_i) s_d.base = wdata_i & ~LOW_MASK;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign mask_o   = s_q.mask;
    assign base_o   = s_q.base;
    assign target_o = s_q.base + VEC_OFS;

endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
    import irq_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            take_i,
    input  logic            restore_i,
    input  logic            wr_i,
    input  logic [1:0]      wdata_i,
    input  logic [XLEN-1:0] pc_i,
    output ie_t             ie_o,
    output logic [XLEN-1:0] ret_o
);

    typedef struct packed {
        ie_t             ie;
        logic [XLEN-1:0] ret;
    } en_state_t;

    en_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take_i) begin
            s_d.ie.saved = 1'b1;
            s_d.ie.gie   = 1'b0;
            s_d.ret      = pc_i;
        end else if (restore_i) begin
            s_d.ie.gie   = s_q.ie.saved;
            s_d.ie.saved = 1'b0;
        end else if (wr_i) begin
            s_d.ie.saved = wdata_i[1];
            s_d.ie.gie   = wdata_i[0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ie_o  = s_q.ie;
    assign ret_o = s_q.ret;

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int NLINES     = 32,
    parameter int XLEN       = 32,
    parameter int VEC_ID     = 6,
    parameter int SLOT_SHIFT = 5,
    parameter int BASE_ALIGN = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NLINES-1:0] irq_lines_i,
    input  logic              insn_done_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              restore_i,
    input  logic              csr_wr_i,
    input  logic [1:0]        csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              take_irq_o,
    output logic [XLEN-1:0]   target_o,
    output logic [XLEN-1:0]   ret_addr_o,
    output logic [1:0]        ie_o
);

    csr_sel_e          sel_w;
    logic [NLINES-1:0] pend_w;
    logic [NLINES-1:0] mask_w;
    logic [XLEN-1:0]   base_w;
    ie_t               ie_w;
    logic              take_w;

    assign sel_w = csr_sel_e'(csr_addr_i);

    irq_pending_reg #(.NLINES(NLINES)) pend_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lines_i   (irq_lines_i),
        .clr_en_i  (csr_wr_i && sel_w == SEL_PEND),
        .clr_bits_i(csr_wdata_i[NLINES-1:0]),
        .pend_o    (pend_w)
    );

    irq_mask_base #(
        .NLINES    (NLINES),
        .XLEN      (XLEN),
        .BASE_ALIGN(BASE_ALIGN),
        .VEC_ID    (VEC_ID),
        .SLOT_SHIFT(SLOT_SHIFT)
    ) mb_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mask_we_i(csr_wr_i && sel_w == SEL_MASK),
        .base_we_i(csr_wr_i && sel_w == SEL_BASE),
        .wdata_i  (csr_wdata_i),
        .mask_o   (mask_w),
        .base_o   (base_w),
        .target_o (target_o)
    );

    // entry decision at the instruction boundary
    always_comb begin
        take_w = insn_done_i && ie_w.gie && (|(mask_w & pend_w));
    end

    irq_enable_ctl #(.XLEN(XLEN)) en_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .take_i   (take_w),
        .restore_i(restore_i),
        .wr_i     (csr_wr_i && sel_w == SEL_ENAB),
        .wdata_i  (csr_wdata_i[1:0]),
        .pc_i     (pc_i),
        .ie_o     (ie_w),
        .ret_o    (ret_addr_o)
    );

    always_comb begin
        unique case (sel_w)
            SEL_PEND: csr_rdata_o = XLEN'(pend_w);
            SEL_MASK: csr_rdata_o = XLEN'(mask_w);
            SEL_ENAB: csr_rdata_o = XLEN'(ie_w);
            default:  csr_rdata_o = base_w;
        endcase
    end

    assign take_irq_o = take_w;
    assign ie_o       = ie_w;

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
    parameter int NLINES = 32,
    parameter int XLEN   = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NLINES-1:0] irq_lines_i,
    input logic              insn_done_i,
    input logic [XLEN-1:0]   pc_i,
    input logic              restore_i,
    input logic              csr_wr_i,
    input logic [1:0]        csr_addr_i,
    input logic [XLEN-1:0]   csr_wdata_i,
    input logic              take_irq_o,
    input logic [XLEN-1:0]   ret_addr_o,
    input logic [1:0]        ie_o,
    input logic [NLINES-1:0] pend_i,
    input logic [NLINES-1:0] mask_i
);

    p_line_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_i & $past(irq_lines_i)) == $past(irq_lines_i)));

    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(csr_wr_i && csr_addr_i == 2'd0) |=> ((pend_i & $past(pend_i)) == $past(pend_i)));

    p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_wr_i && csr_addr_i == 2'd0)
        |=> ((pend_i & $past(csr_wdata_i[NLINES-1:0]) & ~$past(irq_lines_i)) == '0));

    p_take_cond_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_irq_o |-> (ie_o[0] && (|(mask_i & pend_i))));

    p_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_irq_o |-> insn_done_i);

    p_ret_pc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_irq_o |=> (ret_addr_o == $past(pc_i)));

    p_entry_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_irq_o |=> (ie_o == 2'b10));

    p_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restore_i && !take_irq_o) |=> (ie_o == {1'b0, $past(ie_o[1])}));

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.NLINES(NLINES), .XLEN(XLEN)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_lines_i(irq_lines_i),
    .insn_done_i(insn_done_i),
    .pc_i       (pc_i),
    .restore_i  (restore_i),
    .csr_wr_i   (csr_wr_i),
    .csr_addr_i (csr_addr_i),
    .csr_wdata_i(csr_wdata_i),
    .take_irq_o (take_irq_o),
    .ret_addr_o (ret_addr_o),
    .ie_o       (ie_o),
    .pend_i     (pend_w),
    .mask_i     (mask_w)
);

// File: tb/irq_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        done = 1'b0;
    logic [31:0] pc = '0;
    logic        rest = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, target, ret;
    logic        take;
    logic [1:0]  ie;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_entry_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .insn_done_i(done),
        .pc_i(pc), .restore_i(rest), .csr_wr_i(wr), .csr_addr_i(addr),
        .csr_wdata_i(wdata), .csr_rdata_o(rdata), .take_irq_o(take),
        .target_o(target), .ret_addr_o(ret), .ie_o(ie)
    );

    localparam logic [31:0] BASE_W = 32'hABCD_12FF;
    localparam logic [31:0] BASE_X = 32'hABCD_1200;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(logic [1:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step();
        wr = 1'b0;
    endtask

    task automatic csr_read(logic [1:0] a, output logic [31:0] d);
        addr = a; #0.5; d = rdata;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            csr_read(2'(a), v); chk("R1 reg", v, 32'h0);
        end
        chk("R1 take", 32'(take), 0);
        chk("R1 ret", ret, 0);
        // R12 width of mask and enable
        csr_write(2'd1, 32'hFFFF_FFFF); csr_read(2'd1, v); chk("R12 mask", v, 32'hFFFF_FFFF);
        csr_write(2'd2, 32'hFFFF_FFFC); csr_read(2'd2, v); chk("R12 enable", v, 32'h0);
        csr_write(2'd2, 32'hFFFF_FFFF); csr_read(2'd2, v); chk("R12 enable", v, 32'h3);
        // R7 base alignment and target
        csr_write(2'd3, BASE_W); csr_read(2'd3, v); chk("R7 base", v, BASE_X);
        chk("R7 target", target, BASE_X + 32'd192);
        // R4 set wins over a simultaneous clear
        lines = 32'h8; step(); lines = '0;
        lines = 32'h8; csr_write(2'd0, 32'h8); lines = '0;
        csr_read(2'd0, v); chk("R4 set-vs-clear", v, 32'h8);
        csr_write(2'd0, 32'h8); csr_read(2'd0, v); chk("R4 clear", v, 32'h0);

        for (int n = 0; n < 32; n++) begin
            logic [31:0] bit_n;
            bit_n = 32'h1 << n;
            pc = 32'h1000_0000 + 32'(n) * 4;
            csr_write(2'd1, bit_n);
            csr_write(2'd2, 32'h1);
            lines = bit_n; step(); lines = '0;
            csr_read(2'd0, v); chk("R2 pend", v, bit_n);
            step();
            csr_read(2'd0, v); chk("R3 sticky", v, bit_n);
            chk("R6 no boundary", 32'(take), 0);
            done = 1'b1; #0.5;
            chk("R5 take", 32'(take), 1);
            chk("R7 target", target, BASE_X + 32'd192);
            step();
            done = 1'b0;
            chk("R8 ret", ret, pc);
            csr_read(2'd2, v); chk("R9 enable", v, 32'h2);
            done = 1'b1; #0.5;
            chk("R5 gie low", 32'(take), 0);
            done = 1'b0;
            rest = 1'b1; step(); rest = 1'b0;
            csr_read(2'd2, v); chk("R10 restore", v, 32'h1);
            // held off by mask, then released
            csr_write(2'd1, ~bit_n);
            done = 1'b1; #0.5;
            chk("R5 masked", 32'(take), 0);
            done = 1'b0;
            csr_write(2'd1, bit_n);
            csr_read(2'd0, v); chk("R11 still pending", v, bit_n);
            done = 1'b1; #0.5;
            chk("R11 released", 32'(take), 1);
            step(); done = 1'b0;
            rest = 1'b1; step(); rest = 1'b0;
            csr_write(2'd0, bit_n);
            csr_read(2'd0, v); chk("R4 w1c", v, 32'h0);
        end

        // R10 priority: take beats restore, restore beats write
        lines = 32'h1; step(); lines = '0;
        csr_write(2'd1, 32'h1);
        done = 1'b1; rest = 1'b1; step(); done = 1'b0; rest = 1'b0;
        chk("R10 take over restore", 32'(ie), 32'h2);
        wr = 1'b1; addr = 2'd2; wdata = 32'h3; rest = 1'b1;
        step(); wr = 1'b0; rest = 1'b0;
        chk("R10 restore over write", 32'(ie), 32'h1);
        summary();
    end

endmodule